// File: doc/BRIEF.md
# Battery Backup Switch Controller

This block is the digital control for a memory supply that can be backed up by a battery. It receives flags from external comparators. One flag says the main supply is below the reset threshold. Another says the main supply is below the battery voltage. It also reads a backup-enable pin and an active-low chip-enable request from an address decoder. From these it drives the enables of two pass switches, one from the main supply and one from the battery. It also drives a battery-on status output and a gated, active-low chip enable for the memory.

The backup-enable pin is not read continuously. Its level is sampled once, at the moment the supply is seen to fall through the reset threshold, and it is held after that. A held high lets the battery take over once the supply drops below the battery voltage. A held low keeps the battery switch off, which saves the battery. During undervoltage the memory chip enable is forced inactive, so that stray accesses cannot corrupt the memory. The two switch enables are never on together, and a change of source always passes through one clock with both switches off.

All comparator flags and the backup pin pass through two flip-flop stages before use. The chip-enable path is combinational from its input and is gated only by the synchronised undervoltage flag.

Top module: `battery_backup_ctrl`

## Requirements
- R1: After reset, mainSwEn is 1, battSwEn is 0 and battOn is 0, and the held backup status is 1. A below-battery condition with no prior supply fall therefore selects the battery.
- R2: The effective backup level is captured once, when the synchronised supplyLow flag rises from 0 to 1, and it is held from then on. Later changes on the pin have no effect until the next such rising edge.
- R3: With the held status 1 and supplyBelowBatt asserted, battSwEn is 1 and mainSwEn is 0.
- R4: With the held status 0 and supplyBelowBatt asserted, battSwEn stays 0 and mainSwEn stays 1 (battery-saving mode).
- R5: When backupDrive is 0 the backup pin counts as unconnected and reads as 1, whatever the level on backupPin.
- R6: While supplyLow is 0, ceOutN equals ceInN (both active low, 0 means selected).
- R7: While supplyLow is 1, ceOutN is 1 (deselected) for every value of ceInN.
- R8: battOn is 1 only while the battery switch is enabled. It returns to 0 once supplyBelowBatt is deasserted.
- R9: mainSwEn and battSwEn are never 1 together. Whenever either one rises, both were 0 in the previous cycle.
- R10: Every change of a comparator flag or of the backup pin takes effect within 6 clock cycles, after two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyLow | input | 1 | Comparator flag: supply below the reset threshold |
| supplyBelowBatt | input | 1 | Comparator flag: supply below the battery voltage |
| backupPin | input | 1 | Backup-enable pin level |
| backupDrive | input | 1 | 1 when the backup pin is driven; 0 means it is unconnected |
| ceInN | input | 1 | Active-low chip-enable request from the decoder |
| ceOutN | output | 1 | Gated active-low chip enable to the memory |
| mainSwEn | output | 1 | Enable of the main-supply pass switch |
| battSwEn | output | 1 | Enable of the battery pass switch |
| battOn | output | 1 | Status: output is switched to the battery |

## Verification
The assertions assume that the flags are ordered as the real comparators order them. The supply is taken to cross the reset threshold before it drops below the battery voltage, so the held status has settled before any request for the battery. They also assume that the backup pin is stable around the falling crossing. The stimulus changes one input at a time and waits well over the synchroniser delay before each check and before the next change. It never raises supplyBelowBatt in the same cycle as supplyLow.

// File: rtl/bbsw_pkg.sv
package bbsw_pkg;

  // Flag positions inside the synchroniser vector
  localparam int FLAG_LOW    = 0;
  localparam int FLAG_BELOW  = 1;
  localparam int FLAG_BACKUP = 2;
  localparam int NUM_FLAGS   = 3;

  typedef enum logic [1:0] {
    SRC_MAIN  = 2'd0,
    GAP_TO_B  = 2'd1,
    SRC_BATT  = 2'd2,
    GAP_TO_M  = 2'd3
  } srcState_t;

  typedef struct packed {
    logic captureBackup;
    logic driveMain;
    logic driveBatt;
  } swStrobe_t;

endpackage

// File: rtl/bbsw_sync.sv
module bbsw_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chain[s] <= RESET_VAL;
        end else if (s == 0) begin
          chain[s] <= asyncIn;
        end else begin
          chain[s] <= chain[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/bbsw_ctrl.sv
module bbsw_ctrl
  import bbsw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lowSync,
  input  logic      belowSync,
  input  logic      heldBackup,
  output swStrobe_t strobe
);

  srcState_t state, stateNext;
  logic      lowPrev;
  logic      wantBatt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowPrev <= 1'b0;
      state   <= SRC_MAIN;
    end else begin
      lowPrev <= lowSync;
      state   <= stateNext;
    end
  end

  assign wantBatt = belowSync && heldBackup;

  always_comb begin
    stateNext = state;
    unique case (state)
      SRC_MAIN: if (wantBatt)  stateNext = GAP_TO_B;
      GAP_TO_B: stateNext = wantBatt ? SRC_BATT : SRC_MAIN;
      SRC_BATT: if (!wantBatt) stateNext = GAP_TO_M;
      GAP_TO_M: stateNext = wantBatt ? SRC_BATT : SRC_MAIN;
      default:  stateNext = SRC_MAIN;
    endcase
  end

  always_comb begin
    strobe               = '0;
    strobe.captureBackup = lowSync && !lowPrev;
    strobe.driveMain     = (state == SRC_MAIN);
    strobe.driveBatt     = (state == SRC_BATT);
  end

  // R9
  no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SRC_MAIN) |=> (state != SRC_BATT));

  // R9
  no_direct_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SRC_BATT) |=> (state != SRC_MAIN));

endmodule

// File: rtl/bbsw_dp.sv
module bbsw_dp
  import bbsw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  swStrobe_t strobe,
  input  logic      backupSync,
  input  logic      lowSync,
  input  logic      ceInN,
  output logic      heldBackup,
  output logic      mainSwEn,
  output logic      battSwEn,
  output logic      battOn,
  output logic      ceOutN
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldBackup <= 1'b1;
      mainSwEn   <= 1'b1;
      battSwEn   <= 1'b0;
      battOn     <= 1'b0;
    end else begin
      if (strobe.captureBackup) heldBackup <= backupSync;
      mainSwEn <= strobe.driveMain;
      battSwEn <= strobe.driveBatt;
      battOn   <= strobe.driveBatt;
    end
  end

  assign ceOutN = ceInN | lowSync;

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mainSwEn && battSwEn));

  // R9
  batt_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(battSwEn) |-> !$past(mainSwEn));

  // R9
  main_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainSwEn) |-> !$past(battSwEn));

  // R2
  held_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureBackup |=> $stable(heldBackup));

  // R8
  batt_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    battOn |-> battSwEn);

endmodule

// File: rtl/battery_backup_ctrl.sv
module battery_backup_ctrl
  import bbsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLow,
  input  logic supplyBelowBatt,
  input  logic backupPin,
  input  logic backupDrive,
  input  logic ceInN,
  output logic ceOutN,
  output logic mainSwEn,
  output logic battSwEn,
  output logic battOn
);

  localparam logic [NUM_FLAGS-1:0] SYNC_RST = NUM_FLAGS'(1) << FLAG_BACKUP;

  logic [NUM_FLAGS-1:0] rawFlags, syncFlags;
  logic                 pinLevel;
  logic                 heldBackup;
  swStrobe_t            strobe;

  // R5: an undriven pin reads high
  assign pinLevel = backupDrive ? backupPin : 1'b1;

  always_comb begin
    rawFlags              = '0;
    rawFlags[FLAG_LOW]    = supplyLow;
    rawFlags[FLAG_BELOW]  = supplyBelowBatt;
    rawFlags[FLAG_BACKUP] = pinLevel;
  end

  bbsw_sync #(
    .WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawFlags), .syncOut(syncFlags)
  );

  bbsw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .lowSync(syncFlags[FLAG_LOW]),
    .belowSync(syncFlags[FLAG_BELOW]),
    .heldBackup(heldBackup),
    .strobe(strobe)
  );

  bbsw_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .backupSync(syncFlags[FLAG_BACKUP]),
    .lowSync(syncFlags[FLAG_LOW]),
    .ceInN(ceInN),
    .heldBackup(heldBackup),
    .mainSwEn(mainSwEn), .battSwEn(battSwEn),
    .battOn(battOn), .ceOutN(ceOutN)
  );

endmodule

// File: tb/battery_backup_ctrl_tb.sv
module battery_backup_ctrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyLow = 1'b0, supplyBelowBatt = 1'b0;
  logic backupPin = 1'b0, backupDrive = 1'b0, ceInN = 1'b1;
  logic ceOutN, mainSwEn, battSwEn, battOn;

  int checks = 0;
  int fails = 0;
  logic prevMain = 1'b1, prevBatt = 1'b0;

  always #10 clk = ~clk;

  battery_backup_ctrl u_dut (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow),
    .supplyBelowBatt(supplyBelowBatt), .backupPin(backupPin),
    .backupDrive(backupDrive), .ceInN(ceInN), .ceOutN(ceOutN),
    .mainSwEn(mainSwEn), .battSwEn(battSwEn), .battOn(battOn)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // R10: 6 cycles covers synchroniser plus source change
  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    supplyLow = 0; supplyBelowBatt = 0; ceInN = 1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sweepCe(input logic low);
    for (int c = 0; c < 2; c++) begin
      ceInN = c[0];
      repeat (2) @(negedge clk);
      if (low) chk("R7 ceOutN forced", ceOutN, 1'b1);
      else     chk("R6 ceOutN follows", ceOutN, c[0]);
    end
    ceInN = 1'b1;
  endtask

  // R9 monitor: no overlap, gap before each rise
  always @(negedge clk) begin
    if (rstN) begin
      if (mainSwEn && battSwEn) begin
        fails++; checks++;
        $display("FAIL R9 overlap actual=11 expected=not 11");
      end
      if (battSwEn && !prevBatt) chk("R9 gap before batt", prevMain, 1'b0);
      if (mainSwEn && !prevMain) chk("R9 gap before main", prevBatt, 1'b0);
    end
    prevMain = mainSwEn;
    prevBatt = battSwEn;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // pm: 0 = driven low, 1 = driven high, 2 = floating (reads high)
    for (int pm = 0; pm < 3; pm++) begin
      logic expHeld;
      expHeld = (pm != 0);
      doReset();
      chk("R1 reset mainSwEn", mainSwEn, 1'b1);
      chk("R1 reset battSwEn", battSwEn, 1'b0);
      chk("R1 reset battOn", battOn, 1'b0);
      sweepCe(1'b0);
      backupDrive = (pm != 2);
      backupPin = (pm == 1);
      settle();
      supplyLow = 1'b1;
      settle();
      sweepCe(1'b1);
      // R2: change the pin after the capture, must be ignored
      backupDrive = 1'b1;
      backupPin = ~expHeld;
      settle();
      supplyBelowBatt = 1'b1;
      settle();
      if (expHeld) begin
        chk(pm == 2 ? "R5 float batt" : "R3 battSwEn", battSwEn, 1'b1);
        chk("R3 mainSwEn off", mainSwEn, 1'b0);
        chk("R8 battOn on", battOn, 1'b1);
      end else begin
        chk("R4 battSwEn saving", battSwEn, 1'b0);
        chk("R4 mainSwEn kept", mainSwEn, 1'b1);
        chk("R8 battOn off", battOn, 1'b0);
      end
      supplyBelowBatt = 1'b0;
      settle();
      chk("R8 battOn cleared", battOn, 1'b0);
      chk("R8 mainSwEn back", mainSwEn, 1'b1);
      supplyLow = 1'b0;
      settle();
      sweepCe(1'b0);
    end

    // R1: default held high, no supply fall before below-battery
    doReset();
    backupDrive = 1'b1; backupPin = 1'b0;
    supplyBelowBatt = 1'b1;
    settle();
    chk("R1 default backup battSwEn", battSwEn, 1'b1);
    supplyBelowBatt = 1'b0;
    settle();

    // R2: a second fall recaptures (low then high, no reset between)
    supplyLow = 1'b1; settle();
    supplyBelowBatt = 1'b1; settle();
    chk("R2 capture low", battSwEn, 1'b0);
    supplyBelowBatt = 1'b0; supplyLow = 1'b0; settle();
    backupPin = 1'b1; settle();
    supplyBelowBatt = 1'b1; settle();
    chk("R2 no capture without fall", battSwEn, 1'b0);
    supplyBelowBatt = 1'b0; settle();
    supplyLow = 1'b1; settle();
    supplyBelowBatt = 1'b1; settle();
    chk("R2 recapture high", battSwEn, 1'b1);
    chk("R8 battOn recapture", battOn, 1'b1);
    supplyBelowBatt = 1'b0; settle();
    chk("R9 return main", mainSwEn, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule